// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines and sends each one to one of three classes. A source marked fast drives the fast-interrupt output. A source marked normal is either claimed by one of 16 prioritized vector slots, or it is served as non-vectored. Both processor outputs are combinational functions of the request lines and the configuration registers. A request line therefore shows up at the outputs in the same cycle it rises.

Software reaches the block through a simple synchronous register bus. The bus has a word address, a write strobe, a read strobe, write data and combinational read data. The interrupt handler reads the vector register to get the handler address of the best pending slot, or a shared default address when no slot is pending. That read also starts a service, and the value it returns stays frozen until software writes the vector register to acknowledge. While a service is open, only slots that rank above the one being served can raise the normal-interrupt output again.

Top module: `vicTop`

## Requirements
- R1: After reset every register reads zero and both `fiqOut` and `irqOut` are low.
- R2: `fiqOut` is high exactly when some line is high whose enable bit is set and whose class bit is 1 (fast). Lines that are disabled have no effect on it.
- R3: Word 3 reads the mask of lines that are high, enabled and fast. Word 4 reads the mask of lines that are high, enabled and normal (class bit 0).
- R4: With no service open, `irqOut` is high exactly when word 4 is non-zero.
- R5: A slot is pending only when all of these hold: its enable bit (bit 5 of its control word) is set, the source in bits 4:0 is enabled, that source is normal-class, and its line is high.
- R6: When several slots are pending, the lowest-numbered slot wins, and word 5 returns that slot's handler address.
- R7: When no slot is pending, word 5 returns the default address held in word 6.
- R8: A read strobe on word 5 with no service open latches the returned value and opens a service. The value stays held, and a further read returns it unchanged, whatever the lines do, until the acknowledge.
- R9: While a service is open, `irqOut` is the OR of the pending slots numbered below the served slot. Serving the default address counts as rank 16, so all slots may preempt it and non-vectored sources may not.
- R10: A write to word 5 closes the service, after which `irqOut` and word 5 follow R4, R6 and R7 again.
- R11: The register map, by word address, is:
  - word 0: the raw lines (read-only)
  - word 1: the enable mask
  - word 2: the class mask (1 = fast)
  - word 6: the default address
  - words 16+n: the control word of slot n, read back as {enable, source} in bits 5:0
  - words 32+n: the handler address of slot n
  
  Writes to read-only words are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Register word address |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe (needed only to start a service at word 5) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| irqLines | input | 32 | Level-sensitive request lines |
| fiqOut | output | 1 | Fast-interrupt request to the processor |
| irqOut | output | 1 | Normal-interrupt request to the processor |

## Verification
The hardest case to reach from the ports is the preemption window: an open service at a middle-priority slot, with both lower- and higher-ranked requests moving while the latched address must stay put. The bench gets there by raising a line claimed by slot 5 and taking the vector. It then adds a line claimed by slot 2 and shows that only this line lifts `irqOut`, while repeated vector reads still return the slot-5 address. It then acknowledges, takes slot 2 and confirms that slot 5 and a non-vectored line stay masked. A final scenario serves the default address and checks that a vectored line can preempt it.

// File: rtl/vicPkg.sv
package vicPkg;
  localparam int ADDR_W = 6;
  localparam int SLOT_IDX_W = 4;

  localparam logic [ADDR_W-1:0] A_RAW   = 6'd0;
  localparam logic [ADDR_W-1:0] A_EN    = 6'd1;
  localparam logic [ADDR_W-1:0] A_CLS   = 6'd2;
  localparam logic [ADDR_W-1:0] A_FSTAT = 6'd3;
  localparam logic [ADDR_W-1:0] A_ISTAT = 6'd4;
  localparam logic [ADDR_W-1:0] A_VEC   = 6'd5;
  localparam logic [ADDR_W-1:0] A_DEF   = 6'd6;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RAW, SEL_EN, SEL_CLS, SEL_FSTAT, SEL_ISTAT,
    SEL_VEC, SEL_DEF, SEL_SLOTCTL, SEL_SLOTADR
  } rdSel_e;

  typedef struct packed {
    logic wrEnable;
    logic wrClass;
    logic wrDefault;
    logic wrSlotCtl;
    logic wrSlotAdr;
    logic [SLOT_IDX_W-1:0] slotIdx;
    logic takeVector;
    logic ackVector;
    rdSel_e rdSel;
  } vicStrobe_t;
endpackage

// File: rtl/vicCtrl.sv
module vicCtrl
  import vicPkg::*;
#(
  parameter int SLOTS = 16,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LVL_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic              winnerValid,
  input  logic [SLOT_W-1:0] winnerIdx,
  output vicStrobe_t        strobe,
  output logic              serviceActive,
  output logic [LVL_W-1:0]  servedLevel
);
  logic inSlotRange;
  assign inSlotRange = int'(busAddr[SLOT_IDX_W-1:0]) < SLOTS;

  always_comb begin
    strobe = '0;
    strobe.rdSel = SEL_NONE;
    strobe.slotIdx = busAddr[SLOT_IDX_W-1:0];
    unique case (busAddr)
      A_RAW:   strobe.rdSel = SEL_RAW;
      A_EN:    begin strobe.rdSel = SEL_EN;  strobe.wrEnable = busWe; end
      A_CLS:   begin strobe.rdSel = SEL_CLS; strobe.wrClass = busWe; end
      A_FSTAT: strobe.rdSel = SEL_FSTAT;
      A_ISTAT: strobe.rdSel = SEL_ISTAT;
      A_VEC: begin
        strobe.rdSel = SEL_VEC;
        strobe.ackVector = busWe;
        strobe.takeVector = busRe && !busWe && !serviceActive;
      end
      A_DEF:   begin strobe.rdSel = SEL_DEF; strobe.wrDefault = busWe; end
      default: begin
        if (busAddr[5:4] == 2'b01 && inSlotRange) begin
          strobe.rdSel = SEL_SLOTCTL;
          strobe.wrSlotCtl = busWe;
        end else if (busAddr[5:4] == 2'b10 && inSlotRange) begin
          strobe.rdSel = SEL_SLOTADR;
          strobe.wrSlotAdr = busWe;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serviceActive <= 1'b0;
      servedLevel   <= '0;
    end else if (strobe.ackVector) begin
      serviceActive <= 1'b0;
    end else if (strobe.takeVector) begin
      serviceActive <= 1'b1;
      servedLevel   <= winnerValid ? LVL_W'(winnerIdx) : LVL_W'(SLOTS);
    end
  end
endmodule

// File: rtl/vicDatapath.sv
module vicDatapath
  import vicPkg::*;
#(
  parameter int SRCS = 32,
  parameter int SLOTS = 16,
  parameter int DATA_W = 32,
  localparam int SRC_W = $clog2(SRCS),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LVL_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  vicStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [SRCS-1:0]   irqLines,
  input  logic              serviceActive,
  input  logic [LVL_W-1:0]  servedLevel,
  output logic              winnerValid,
  output logic [SLOT_W-1:0] winnerIdx,
  output logic              fiqOut,
  output logic              irqOut
);
  logic [SRCS-1:0]   enReg, clsReg, fastAct, normAct;
  logic [DATA_W-1:0] defAddr, heldAddr, liveAddr;
  logic [SRC_W-1:0]  slotSrc [SLOTS];
  logic [DATA_W-1:0] slotAdr [SLOTS];
  logic [SLOTS-1:0]  slotOn, slotPend, preemptMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= '0;
      clsReg   <= '0;
      defAddr  <= '0;
      heldAddr <= '0;
    end else begin
      if (strobe.wrEnable)   enReg   <= busWdata[SRCS-1:0];
      if (strobe.wrClass)    clsReg  <= busWdata[SRCS-1:0];
      if (strobe.wrDefault)  defAddr <= busWdata;
      if (strobe.takeVector) heldAddr <= liveAddr;
    end
  end

  assign fastAct = irqLines & enReg & clsReg;
  assign normAct = irqLines & enReg & ~clsReg;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotSrc[s] <= '0;
        slotOn[s]  <= 1'b0;
        slotAdr[s] <= '0;
      end else begin
        if (strobe.wrSlotCtl && int'(strobe.slotIdx) == s) begin
          slotSrc[s] <= busWdata[SRC_W-1:0];
          slotOn[s]  <= busWdata[SRC_W];
        end
        if (strobe.wrSlotAdr && int'(strobe.slotIdx) == s)
          slotAdr[s] <= busWdata;
      end
    end
    assign slotPend[s]    = slotOn[s] & normAct[slotSrc[s]];
    assign preemptMask[s] = LVL_W'(s) < servedLevel;
  end

  always_comb begin
    winnerValid = 1'b0;
    winnerIdx   = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (slotPend[s]) begin
        winnerValid = 1'b1;
        winnerIdx   = SLOT_W'(s);
      end
    end
  end

  assign liveAddr = winnerValid ? slotAdr[winnerIdx] : defAddr;
  assign fiqOut   = |fastAct;
  assign irqOut   = serviceActive ? |(slotPend & preemptMask) : |normAct;

  logic [SLOT_W-1:0] rdSlot;
  assign rdSlot = strobe.slotIdx[SLOT_W-1:0];

  always_comb begin
    busRdata = '0;
    unique case (strobe.rdSel)
      SEL_RAW:     busRdata = DATA_W'(irqLines);
      SEL_EN:      busRdata = DATA_W'(enReg);
      SEL_CLS:     busRdata = DATA_W'(clsReg);
      SEL_FSTAT:   busRdata = DATA_W'(fastAct);
      SEL_ISTAT:   busRdata = DATA_W'(normAct);
      SEL_VEC:     busRdata = serviceActive ? heldAddr : liveAddr;
      SEL_DEF:     busRdata = defAddr;
      SEL_SLOTCTL: busRdata = DATA_W'({slotOn[rdSlot], slotSrc[rdSlot]});
      SEL_SLOTADR: busRdata = slotAdr[rdSlot];
      default:     busRdata = '0;
    endcase
  end
endmodule

// File: rtl/vicTop.sv
module vicTop
  import vicPkg::*;
#(
  parameter int SRCS = 32,
  parameter int SLOTS = 16,
  parameter int DATA_W = 32,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LVL_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [SRCS-1:0]   irqLines,
  output logic              fiqOut,
  output logic              irqOut
);
  vicStrobe_t        strobe;
  logic              serviceActive, winnerValid;
  logic [LVL_W-1:0]  servedLevel;
  logic [SLOT_W-1:0] winnerIdx;

  vicCtrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .winnerValid(winnerValid), .winnerIdx(winnerIdx), .strobe(strobe),
    .serviceActive(serviceActive), .servedLevel(servedLevel)
  );

  vicDatapath #(.SRCS(SRCS), .SLOTS(SLOTS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .irqLines(irqLines), .serviceActive(serviceActive),
    .servedLevel(servedLevel), .winnerValid(winnerValid), .winnerIdx(winnerIdx),
    .fiqOut(fiqOut), .irqOut(irqOut)
  );
endmodule

// File: rtl/vicChecker.sv
module vicChecker
  import vicPkg::*;
#(
  parameter int SRCS = 32,
  parameter int LVL_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              busRe,
  input logic [SRCS-1:0]   irqLines,
  input logic              fiqOut,
  input logic              irqOut,
  input logic              serviceActive,
  input logic [LVL_W-1:0]  servedLevel
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!fiqOut && !irqOut && !serviceActive));

  p_no_fiq_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (irqLines == '0) |-> !fiqOut);

  p_no_irq_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (irqLines == '0) |-> !irqOut);

  p_take_on_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serviceActive) |-> $past(busRe && !busWe && busAddr == A_VEC));

  p_top_slot_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (serviceActive && servedLevel == '0) |-> !irqOut);

  p_ack_closes_r10: assert property (@(posedge clk) disable iff (!rstN)
    (serviceActive && busWe && busAddr == A_VEC) |=> !serviceActive);
endmodule

bind vicTop vicChecker #(.SRCS(SRCS), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
  .irqLines(irqLines), .fiqOut(fiqOut), .irqOut(irqOut),
  .serviceActive(serviceActive), .servedLevel(servedLevel)
);

// File: tb/tb_vicTop.sv
module tb_vicTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [31:0] busWdata = '0, busRdata;
  logic [31:0] irqLines = '0;
  logic        fiqOut, irqOut;
  int nChecks = 0, nBad = 0;
  bit finished = 0;

  localparam logic [5:0] VEC = 6'd5;
  localparam logic [31:0] DEF = 32'h0000_DEF0;

  vicTop dut (.*);

  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic peek(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; #1 d = busRdata;
  endtask

  task automatic take(output logic [31:0] d);
    @(negedge clk); busAddr = VEC; busRe = 1'b1; #1 d = busRdata;
    @(negedge clk); busRe = 1'b0;
  endtask

  task automatic setLines(logic [31:0] v);
    @(negedge clk); irqLines = v; #1;
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R1 fiq", 32'(fiqOut), 0);
    chk("R1 irq", 32'(irqOut), 0);
    foreach (d[i]) if (i < 7) begin peek(6'(i), d); chk("R1 reg", d, 0); end
    peek(6'd16, d); chk("R1 slotctl", d, 0);
    peek(6'd47, d); chk("R1 slotadr", d, 0);
  endtask

  task automatic testRegMap();
    logic [31:0] d;
    wr(6'd1, 32'hA5A5_5A5A); peek(6'd1, d); chk("R11 enable", d, 32'hA5A5_5A5A);
    wr(6'd2, 32'h0F0F_F0F0); peek(6'd2, d); chk("R11 class", d, 32'h0F0F_F0F0);
    wr(6'd6, DEF); peek(6'd6, d); chk("R11 default", d, DEF);
    wr(6'd19, 32'hFFFF_FFFF); peek(6'd19, d); chk("R11 slotctl", d, 32'h3F);
    wr(6'd35, 32'h1234_5678); peek(6'd35, d); chk("R11 slotadr", d, 32'h1234_5678);
    wr(6'd19, 0); wr(6'd35, 0);
    wr(6'd0, 32'hFFFF); peek(6'd0, d); chk("R11 raw ro", d, 0);
  endtask

  task automatic testClasses();
    logic [31:0] d;
    wr(6'd1, 32'hFFFF_FFFF); wr(6'd2, 32'h0000_000F);
    setLines(32'h2);
    chk("R2 fiq", 32'(fiqOut), 1); chk("R4 irq", 32'(irqOut), 0);
    peek(6'd3, d); chk("R3 fstat", d, 32'h2);
    peek(6'd4, d); chk("R3 istat", d, 0);
    setLines(32'h100);
    chk("R2 fiq low", 32'(fiqOut), 0); chk("R4 irq", 32'(irqOut), 1);
    peek(6'd4, d); chk("R3 istat", d, 32'h100);
    wr(6'd1, ~32'h100); #1;
    chk("R4 disabled", 32'(irqOut), 0);
    peek(6'd4, d); chk("R3 istat disabled", d, 0);
    wr(6'd1, ~32'h2); setLines(32'h2);
    chk("R2 disabled", 32'(fiqOut), 0);
    wr(6'd1, 32'hFFFF_FFFF); setLines(0);
  endtask

  task automatic testPriority();
    logic [31:0] d;
    wr(6'd18, 32'h27); wr(6'd34, 32'h200);
    wr(6'd21, 32'h29); wr(6'd37, 32'h500);
    wr(6'd16, 32'h0B); wr(6'd32, 32'h100);
    setLines((1 << 7) | (1 << 9));
    peek(VEC, d); chk("R6 lowest slot", d, 32'h200);
    setLines(1 << 9);
    peek(VEC, d); chk("R6 single slot", d, 32'h500);
    setLines(1 << 11);
    peek(VEC, d); chk("R7 slot off", d, DEF);
    chk("R4 nonvectored", 32'(irqOut), 1);
    wr(6'd2, 32'h0000_020F); setLines(1 << 9);
    peek(VEC, d); chk("R5 fast source", d, DEF);
    chk("R2 fiq", 32'(fiqOut), 1);
    wr(6'd2, 32'h0000_000F); wr(6'd1, ~(32'h1 << 9));
    peek(VEC, d); chk("R5 source disabled", d, DEF);
    wr(6'd1, 32'hFFFF_FFFF); setLines(0);
  endtask

  task automatic testNesting();
    logic [31:0] d;
    setLines(1 << 9);
    take(d); chk("R8 take", d, 32'h500);
    chk("R9 masked", 32'(irqOut), 0);
    setLines((1 << 9) | (1 << 7));
    chk("R9 preempt", 32'(irqOut), 1);
    take(d); chk("R8 held reread", d, 32'h500);
    setLines(1 << 7);
    peek(VEC, d); chk("R8 held lines", d, 32'h500);
    wr(VEC, 0); #1;
    chk("R10 irq after ack", 32'(irqOut), 1);
    peek(VEC, d); chk("R10 live", d, 32'h200);
    take(d); chk("R8 take2", d, 32'h200);
    setLines((1 << 9) | (1 << 20));
    chk("R9 lower masked", 32'(irqOut), 0);
    wr(VEC, 0); #1;
    chk("R10 reopen", 32'(irqOut), 1);
    setLines(0);
  endtask

  task automatic testDefault();
    logic [31:0] d;
    setLines(1 << 20);
    take(d); chk("R7 take default", d, DEF);
    chk("R9 default masks nonvec", 32'(irqOut), 0);
    setLines((1 << 20) | (1 << 9));
    chk("R9 slot preempts default", 32'(irqOut), 1);
    wr(VEC, 0); setLines(0);
    chk("R10 idle", 32'(irqOut), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    testReset();
    testRegMap();
    testClasses();
    testPriority();
    testNesting();
    testDefault();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      nChecks++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end
endmodule